// File: doc/BRIEF.md
# Dual-Channel Conversion Result Serializer

This block is the output shifter of a serial converter port. At the start of each frame it takes two parallel two's-complement results, channel A and channel B, and an optional register readback word. It then shifts them out, MSB first, on two data lines that can be released to high impedance. Two configuration bits pick one of four arrangements. The clock mode sets how many serial clock falls pass before the first data bit. The lane mode sets whether the two channels travel on separate lines or one after the other on line A. The same frame start that loads the shifter also raises a one-cycle conversion-start pulse for the converter core.

The block runs on the system clock. The chip select level and the serial clock falling-edge strobe arrive already synchronized, the strobe lasting one cycle. Each data line has a value output and an enable output, and the pad ring joins them into a three-state pin. The result width is the parameter `RES_W`, 12, 14 or 16. Each result is left-aligned in a 16-fall slot, so the unused tail of a narrow result reads as zeros.

Top module: `dual_result_serializer`

## Requirements
- R1: One cycle after the block sees chip select fall, line A is enabled and driving 0, and line B is enabled and driving 0 in dual-lane mode. One cycle after chip select rises, both enables are 0 and both values are 0.
- R2: `conv_start` is high for exactly the one cycle after a chip select fall is seen, and is low at all other times.
- R3: With clock mode 0 (32-clock), the data lines read 0 after serial falls 1 to 15. The MSB appears after fall 16, and each later fall moves to the next lower bit.
- R4: With clock mode 1 (16-clock), the data lines read 0 after fall 1, and the MSB appears after fall 2.
- R5: With lane mode 0 (dual), line A carries channel A and line B carries channel B in the same fall slots.
- R6: With lane mode 1 (single), line B stays disabled for the whole frame. On line A, channel B's MSB comes 16 falls after channel A's MSB: after fall 32 in 32-clock mode and after fall 18 in 16-clock mode.
- R7: Every fall after a channel's LSB, and every fall after the last data slot, yields 0. This holds up to and past the saturation of the fall counter.
- R8: The results, the readback request and both mode bits are captured at the chip select fall. Changing them during the frame has no effect on that frame's output.
- R9: If `rb_valid` is high when chip select falls, line A sends `rb_word` MSB first on falls 1 to 16 and 0 afterwards, in place of any conversion data. Line B, if enabled, sends only 0.
- R10: The results are sent unchanged in two's complement. For example, a negative full-scale code (MSB 1, all other bits 0) appears as a single 1 followed by zeros.
- R11: A serial fall strobe is ignored while chip select is high and in the same cycle as the chip select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Synchronized chip select level, active low |
| sclk_fall | input | 1 | One-cycle strobe marking a serial clock falling edge |
| clk_mode | input | 1 | 0 = 32-clock slot layout, 1 = 16-clock slot layout |
| lane_mode | input | 1 | 0 = dual lane, 1 = single lane on line A |
| res_a | input | RES_W | Channel A two's-complement result |
| res_b | input | RES_W | Channel B two's-complement result |
| rb_valid | input | 1 | Readback word pending for the next frame |
| rb_word | input | 16 | Register readback word |
| conv_start | output | 1 | One-cycle conversion-start pulse per frame |
| sdo_a | output | 1 | Line A data value |
| sdo_a_oe | output | 1 | Line A drive enable |
| sdo_b | output | 1 | Line B data value |
| sdo_b_oe | output | 1 | Line B drive enable |

## Verification
The assertions assume the chip select input holds steady for at least one cycle between changes. They also assume the fall strobe is a clean single-cycle pulse already in the clock domain, since the fall counter may advance by at most one per cycle. The stimulus drives every input on the falling half of the clock, leaves an idle cycle between strobes, and keeps chip select high for several cycles between frames. The fall counter saturates, so the frames run past the last data slot and bring out the trailing zeros without leaving the legal range.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int CNT_W = 6;
  localparam int SLOT  = 16;

  typedef logic [SLOT-1:0]  slot_word_t;
  typedef logic [CNT_W-1:0] fall_cnt_t;

  typedef enum logic { CLK_32 = 1'b0, CLK_16 = 1'b1 } clk_mode_e;
  typedef enum logic { LANE_DUAL = 1'b0, LANE_SINGLE = 1'b1 } lane_mode_e;

  localparam fall_cnt_t FIRST_32 = fall_cnt_t'(16);
  localparam fall_cnt_t FIRST_16 = fall_cnt_t'(2);
  localparam fall_cnt_t FIRST_RB = fall_cnt_t'(1);
  localparam fall_cnt_t CNT_MAX  = '1;

  // Bit of a left-aligned 16-bit slot word shown after fall number cnt,
  // where the slot opens at fall number first.
  function automatic logic slot_pick(input slot_word_t w, input fall_cnt_t cnt,
                                     input fall_cnt_t first);
    fall_cnt_t rel;
    rel = cnt - first;
    if ((cnt >= first) && (rel < fall_cnt_t'(SLOT)))
      return w[~rel[3:0]];
    return 1'b0;
  endfunction
endpackage

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import ser_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      sclk_fall,
  output logic      start,
  output logic      active_nxt,
  output fall_cnt_t cnt_nxt,
  output fall_cnt_t cnt_q,
  output logic      conv_start
);
  logic cs_q;
  logic active_q;
  logic count_en;

  always_comb begin
    start      = cs_q & ~cs_n;
    count_en   = active_q & ~cs_n & sclk_fall & ~start;
    active_nxt = start | (active_q & ~cs_n);
    cnt_nxt    = cnt_q;
    if (start)
      cnt_nxt = '0;
    else if (count_en && (cnt_q != CNT_MAX))
      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      active_q   <= 1'b0;
      cnt_q      <= '0;
      conv_start <= 1'b0;
    end else begin
      cs_q       <= cs_n;
      active_q   <= active_nxt;
      cnt_q      <= cnt_nxt;
      conv_start <= start;
    end
  end

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(cnt_q));
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cs_n && !start) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ser_capture.sv
module ser_capture
  import ser_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             rb_valid,
  input  slot_word_t       rb_word,
  input  logic             clk_mode,
  input  logic             lane_mode,
  output slot_word_t       word_q [2],
  output logic             rb_pend_q,
  output slot_word_t       rb_word_q,
  output logic             clk16_q,
  output logic             single_q,
  output logic             single_nxt
);
  localparam int PAD = SLOT - RES_W;

  logic [RES_W-1:0] res_in [2];
  slot_word_t       word_nxt [2];
  logic             rb_pend_nxt;
  slot_word_t       rb_word_nxt;
  logic             clk16_nxt;

  assign res_in[0] = res_a;
  assign res_in[1] = res_b;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    slot_word_t aligned;
    if (PAD == 0) begin : g_full
      assign aligned = slot_word_t'(res_in[ch]);
    end else begin : g_pad
      assign aligned = slot_word_t'(res_in[ch]) << PAD;
    end

    always_comb begin
      word_nxt[ch] = word_q[ch];
      if (start) word_nxt[ch] = aligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[ch] <= '0;
      else        word_q[ch] <= word_nxt[ch];
    end
  end

  always_comb begin
    rb_pend_nxt = rb_pend_q;
    rb_word_nxt = rb_word_q;
    clk16_nxt   = clk16_q;
    single_nxt  = single_q;
    if (start) begin
      rb_pend_nxt = rb_valid;
      rb_word_nxt = rb_word;
      clk16_nxt   = clk_mode;
      single_nxt  = lane_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_pend_q <= 1'b0;
      rb_word_q <= '0;
      clk16_q   <= 1'b0;
      single_q  <= 1'b0;
    end else begin
      rb_pend_q <= rb_pend_nxt;
      rb_word_q <= rb_word_nxt;
      clk16_q   <= clk16_nxt;
      single_q  <= single_nxt;
    end
  end

  p_hold_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(single_q) && $stable(clk16_q) && $stable(rb_pend_q));
endmodule

// File: rtl/ser_slot_decode.sv
module ser_slot_decode
  import ser_pkg::*;
(
  input  fall_cnt_t  cnt,
  input  slot_word_t word [2],
  input  logic       rb_pend,
  input  slot_word_t rb_word,
  input  logic       clk16,
  input  logic       single,
  output logic [1:0] lane_bit
);
  fall_cnt_t first_a;
  fall_cnt_t first_b;

  always_comb begin
    first_a  = (clk16 == CLK_16) ? FIRST_16 : FIRST_32;
    first_b  = (single == LANE_SINGLE) ? first_a + fall_cnt_t'(SLOT) : first_a;
    lane_bit = 2'b00;
    if (rb_pend) begin
      lane_bit[0] = slot_pick(rb_word, cnt, FIRST_RB);
    end else if (single == LANE_SINGLE) begin
      lane_bit[0] = slot_pick(word[0], cnt, first_a) | slot_pick(word[1], cnt, first_b);
    end else begin
      lane_bit[0] = slot_pick(word[0], cnt, first_a);
      lane_bit[1] = slot_pick(word[1], cnt, first_b);
    end
  end
endmodule

// File: rtl/ser_lane_drv.sv
module ser_lane_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_nxt,
  input  logic [1:0] lane_en_nxt,
  input  logic [1:0] lane_bit,
  output logic [1:0] sdo,
  output logic [1:0] sdo_oe
);
  logic [1:0] sdo_nxt;
  logic [1:0] oe_nxt;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    always_comb begin
      oe_nxt[ln]  = active_nxt & lane_en_nxt[ln];
      sdo_nxt[ln] = oe_nxt[ln] & lane_bit[ln];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sdo[ln]    <= 1'b0;
        sdo_oe[ln] <= 1'b0;
      end else begin
        sdo[ln]    <= sdo_nxt[ln];
        sdo_oe[ln] <= oe_nxt[ln];
      end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe[ln] |-> !sdo[ln]);
  end

  p_b_with_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe[1] |-> sdo_oe[0]);
endmodule

// File: rtl/dual_result_serializer.sv
module dual_result_serializer
  import ser_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk_fall,
  input  logic             clk_mode,
  input  logic             lane_mode,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             rb_valid,
  input  logic [15:0]      rb_word,
  output logic             conv_start,
  output logic             sdo_a,
  output logic             sdo_a_oe,
  output logic             sdo_b,
  output logic             sdo_b_oe
);
  logic       start;
  logic       active_nxt;
  fall_cnt_t  cnt_nxt;
  fall_cnt_t  cnt_q;
  slot_word_t word_q [2];
  logic       rb_pend_q;
  slot_word_t rb_word_q;
  logic       clk16_q;
  logic       single_q;
  logic       single_nxt;
  logic [1:0] lane_bit;
  logic [1:0] lane_en_nxt;
  logic [1:0] sdo;
  logic [1:0] sdo_oe;

  ser_frame_ctrl u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk_fall  (sclk_fall),
    .start      (start),
    .active_nxt (active_nxt),
    .cnt_nxt    (cnt_nxt),
    .cnt_q      (cnt_q),
    .conv_start (conv_start)
  );

  ser_capture #(.RES_W(RES_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .res_a      (res_a),
    .res_b      (res_b),
    .rb_valid   (rb_valid),
    .rb_word    (rb_word),
    .clk_mode   (clk_mode),
    .lane_mode  (lane_mode),
    .word_q     (word_q),
    .rb_pend_q  (rb_pend_q),
    .rb_word_q  (rb_word_q),
    .clk16_q    (clk16_q),
    .single_q   (single_q),
    .single_nxt (single_nxt)
  );

  ser_slot_decode u_decode (
    .cnt      (cnt_nxt),
    .word     (word_q),
    .rb_pend  (rb_pend_q),
    .rb_word  (rb_word_q),
    .clk16    (clk16_q),
    .single   (single_q),
    .lane_bit (lane_bit)
  );

  assign lane_en_nxt = {~single_nxt, 1'b1};

  ser_lane_drv u_lanes (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_nxt  (active_nxt),
    .lane_en_nxt (lane_en_nxt),
    .lane_bit    (lane_bit),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  assign sdo_a    = sdo[0];
  assign sdo_b    = sdo[1];
  assign sdo_a_oe = sdo_oe[0];
  assign sdo_b_oe = sdo_oe[1];

  p_single_b_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_q && sdo_a_oe) |-> !sdo_b_oe);
  p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_a_oe && !rb_pend_q && !clk16_q && (cnt_q < FIRST_32)) |-> !sdo_a);
  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_a_oe && !rb_pend_q && clk16_q && (cnt_q < FIRST_16)) |-> !sdo_a);
  p_rb_b_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_pend_q && sdo_b_oe) |-> !sdo_b);
  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > fall_cnt_t'(47)) |-> (!sdo_a && !sdo_b));
endmodule

// File: tb/dual_result_serializer_bench.sv
module dual_result_serializer_bench;
  localparam int RES_W  = 16;
  localparam int NFALLS = 50;
  localparam int NVEC   = 8;
  // {clk_mode, lane_mode, res_a, res_b}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 16'h8000, 16'h7FFF},
    {1'b0, 1'b1, 16'hA5C3, 16'h3C5A},
    {1'b1, 1'b0, 16'hFFFF, 16'h0001},
    {1'b1, 1'b1, 16'h8000, 16'h8001},
    {1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {1'b0, 1'b1, 16'h0001, 16'h8000},
    {1'b1, 1'b0, 16'h1234, 16'hFEDC},
    {1'b1, 1'b1, 16'h7FFF, 16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk_fall = 1'b0;
  logic clk_mode = 1'b0;
  logic lane_mode = 1'b0;
  logic [RES_W-1:0] res_a = '0;
  logic [RES_W-1:0] res_b = '0;
  logic rb_valid = 1'b0;
  logic [15:0] rb_word = '0;
  logic conv_start, sdo_a, sdo_a_oe, sdo_b, sdo_b_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] got_a, got_b, oe_a_seen, oe_b_seen;

  always #2 clk = ~clk;

  dual_result_serializer #(.RES_W(RES_W)) u_dual_result_serializer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
    .clk_mode(clk_mode), .lane_mode(lane_mode), .res_a(res_a), .res_b(res_b),
    .rb_valid(rb_valid), .rb_word(rb_word), .conv_start(conv_start),
    .sdo_a(sdo_a), .sdo_a_oe(sdo_a_oe), .sdo_b(sdo_b), .sdo_b_oe(sdo_b_oe)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_a(input int k, input logic cm, input logic lm,
                                 input logic [15:0] a, input logic [15:0] b,
                                 input logic rbv, input logic [15:0] rbw);
    int first;
    if (rbv) return (k >= 1 && k <= 16) ? rbw[16-k] : 1'b0;
    first = cm ? 2 : 16;
    if (k >= first && k < first + RES_W) return a[RES_W-1-(k-first)];
    if (lm && k >= first + 16 && k < first + 16 + RES_W) return b[RES_W-1-(k-first-16)];
    return 1'b0;
  endfunction

  function automatic logic exp_b(input int k, input logic cm, input logic lm,
                                 input logic [15:0] b, input logic rbv);
    int first;
    if (rbv || lm) return 1'b0;
    first = cm ? 2 : 16;
    if (k >= first && k < first + RES_W) return b[RES_W-1-(k-first)];
    return 1'b0;
  endfunction

  task automatic fall_once(input int k);
    sclk_fall = 1'b1;
    @(negedge clk);
    sclk_fall = 1'b0;
    got_a[k] = sdo_a;
    got_b[k] = sdo_b;
    oe_a_seen[k] = sdo_a_oe;
    oe_b_seen[k] = sdo_b_oe;
    @(negedge clk);
  endtask

  // Opens a frame; checks R1 and R2 right after the chip select fall.
  task automatic open_frame(input logic cm, input logic lm, input logic [15:0] a,
                            input logic [15:0] b, input logic rbv, input logic [15:0] rbw);
    clk_mode = cm; lane_mode = lm; res_a = a; res_b = b; rb_valid = rbv; rb_word = rbw;
    cs_n = 1'b0;
    @(negedge clk);
    check(conv_start === 1'b1, "R2 conv_start after CS fall", 64'(conv_start), 64'd1);
    check(sdo_a_oe === 1'b1 && sdo_a === 1'b0 && sdo_b === 1'b0 && sdo_b_oe === !lm,
          "R1 lines driven 0 at frame start", {60'd0, sdo_a_oe, sdo_a, sdo_b_oe, sdo_b},
          {60'd0, 1'b1, 1'b0, !lm, 1'b0});
    @(negedge clk);
    check(conv_start === 1'b0, "R2 conv_start single cycle", 64'(conv_start), 64'd0);
    rb_valid = 1'b0;
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    @(negedge clk);
    check(!sdo_a_oe && !sdo_b_oe && !sdo_a && !sdo_b, "R1 lines released on CS rise",
          {60'd0, sdo_a_oe, sdo_a, sdo_b_oe, sdo_b}, 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_streams(input string req, input int n, input logic cm, input logic lm,
                                 input logic [15:0] a, input logic [15:0] b,
                                 input logic rbv, input logic [15:0] rbw);
    logic [63:0] ea, eb;
    ea = '0; eb = '0;
    for (int k = 1; k <= n; k++) begin
      ea[k] = exp_a(k, cm, lm, a, b, rbv, rbw);
      eb[k] = exp_b(k, cm, lm, b, rbv);
    end
    check(got_a === ea, {req, " line A stream"}, got_a, ea);
    check(got_b === eb, {req, " line B stream"}, got_b, eb);
    check(oe_b_seen === (lm ? 64'd0 : ((64'd1 << (n + 1)) - 64'd2)),
          {req, " line B enable (R6)"}, oe_b_seen,
          lm ? 64'd0 : ((64'd1 << (n + 1)) - 64'd2));
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic cm, lm;
    logic [15:0] va, vb;
    repeat (3) @(negedge clk);
    check(!sdo_a_oe && !sdo_b_oe && !conv_start && !sdo_a && !sdo_b, "R1 reset state",
          {59'd0, conv_start, sdo_a_oe, sdo_a, sdo_b_oe, sdo_b}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R3, R4, R5, R6, R7, R10
    for (int v = 0; v < NVEC; v++) begin
      {cm, lm, va, vb} = VEC[v];
      got_a = '0; got_b = '0; oe_a_seen = '0; oe_b_seen = '0;
      open_frame(cm, lm, va, vb, 1'b0, 16'h0);
      for (int k = 1; k <= NFALLS; k++) fall_once(k);
      compare_streams(cm ? "R4 R5 R6 R7 R10" : "R3 R5 R6 R7 R10",
                      NFALLS, cm, lm, va, vb, 1'b0, 16'h0);
      close_frame();
    end

    // R8: inputs change mid-frame, output follows captured values
    got_a = '0; got_b = '0; oe_a_seen = '0; oe_b_seen = '0;
    open_frame(1'b0, 1'b0, 16'hC3A5, 16'h5A3C, 1'b0, 16'h0);
    res_a = 16'h0000; res_b = 16'hFFFF; clk_mode = 1'b1; lane_mode = 1'b1; rb_valid = 1'b1;
    for (int k = 1; k <= NFALLS; k++) fall_once(k);
    compare_streams("R8", NFALLS, 1'b0, 1'b0, 16'hC3A5, 16'h5A3C, 1'b0, 16'h0);
    rb_valid = 1'b0;
    close_frame();

    // R9: readback replaces channel data from fall 1
    got_a = '0; got_b = '0; oe_a_seen = '0; oe_b_seen = '0;
    open_frame(1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 16'h3A51);
    for (int k = 1; k <= NFALLS; k++) fall_once(k);
    compare_streams("R9", NFALLS, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 16'h3A51);
    close_frame();

    // R11: strobes while CS high and in the CS fall cycle are ignored
    for (int i = 0; i < 3; i++) begin
      sclk_fall = 1'b1; @(negedge clk); sclk_fall = 1'b0; @(negedge clk);
    end
    clk_mode = 1'b1; lane_mode = 1'b0; res_a = 16'hFFFF; res_b = 16'hFFFF;
    cs_n = 1'b0; sclk_fall = 1'b1;
    @(negedge clk);
    sclk_fall = 1'b0;
    @(negedge clk);
    got_a = '0; got_b = '0;
    fall_once(1);
    check(got_a[1] === 1'b0 && got_b[1] === 1'b0, "R11 fall 1 still zero",
          64'({got_a[1], got_b[1]}), 64'd0);
    fall_once(2);
    check(got_a[2] === 1'b1 && got_b[2] === 1'b1, "R11 R4 MSB on fall 2",
          64'({got_a[2], got_b[2]}), 64'd3);

    // R1 abort mid-frame, then a fresh frame restarts the slot count
    for (int k = 3; k <= 10; k++) fall_once(k);
    close_frame();
    got_a = '0; got_b = '0; oe_a_seen = '0; oe_b_seen = '0;
    open_frame(1'b1, 1'b1, 16'h9001, 16'h8000, 1'b0, 16'h0);
    for (int k = 1; k <= 40; k++) fall_once(k);
    compare_streams("R6 R10 after abort", 40, 1'b1, 1'b1, 16'h9001, 16'h8000, 1'b0, 16'h0);
    close_frame();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule